// File: doc/BRIEF.md
# Self-Synchronizing Packet Verifier

This block checks a received stream of test packets without needing any framing from the sender. It keeps its own copy of the test pattern generator, configured with the same pattern mode, seed and packet length as the transmitter. It waits for data to show up, locks onto it, and from then on compares every received word with the word it expects.

The receive path can deliver a word in which only some byte lanes carry data, because unpacking leaves idle bytes between packets. The verifier first squeezes out the idle lanes. It then assembles the surviving bytes, in arrival order, into full 32-bit comparison words.

While locked, the verifier counts mismatching bits and mismatching bytes separately, so a single flipped bit can be told apart from a burst. It also counts packets that arrived without any error and the number of times lock was lost. Lock is deliberately tolerant. It is gained when a word is within a bit-error limit of the seed, and it is only dropped after a run of consecutive words each exceeding a second limit. Software reads the four counters through a small read port and clears them with a one-cycle strobe.

Top module: `pkt_verifier`

## Requirements
- R1: Byte lanes with their valid flag low are discarded. Valid bytes are taken lane 0 first (lane i is `rx_data_i[8i+7:8i]`) and across cycles in arrival order. Each group of four consecutive valid bytes forms one comparison word, with the earliest byte placed in bits 7:0.
- R2: The expected words depend on `cfg_mode_i`, and the first expected word is always `cfg_pat_i`.
  - Mode 0 (and mode 3) repeats `cfg_pat_i`.
  - Mode 1 adds 1 per word, modulo 2^32.
  - Mode 2 steps s to (s >> 1) XOR (s[0] ? 32'h80200003 : 0).
  - The sequence continues across packet boundaries.
- R3: While unlocked, each comparison word is checked against `cfg_pat_i`.
  - If the number of differing bits is at most `cfg_sync_lim_i`, `sync_o` goes high and that word counts as word 0 of a packet.
  - Otherwise the verifier stays unlocked and the expected word stays at the seed.
- R4: While locked, every compared word adds its number of differing bits to the bit-error counter. It also adds its number of differing bytes to the byte-error counter. Words compared while unlocked add nothing.
- R5: While locked, a word whose differing-bit count exceeds `cfg_err_lim_i` is bad, and a word that is not bad ends the run.
  - When `cfg_loss_run_i` consecutive bad words are seen (0 is taken as 1), `sync_o` falls and the sync-loss counter increments.
  - After that, the next word is an acquisition attempt against the seed.
- R6: A packet is `cfg_len_i` words (0 taken as 1), starting at the acquisition word. The good-packet counter increments when all its words had zero differing bits. A packet cut short by loss of lock is never counted.
- R7: `rd_data_o` combinationally shows the counter selected by `rd_addr_i`: 0 bit errors, 1 byte errors, 2 good packets, 3 sync losses.
- R8: Every counter saturates at 2^CNT_W-1 and never wraps.
- R9: A high `cnt_clr_i` zeroes all four counters at the next clock edge and takes priority over any increment. It does not change the lock state.
- R10: Counter updates and `sync_o` changes caused by a word appear at the second rising clock edge after the cycle in which the word's last byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 2 | Pattern mode (0 fixed, 1 increment, 2 PRBS) |
| cfg_pat_i | input | 32 | Seed / fixed pattern value |
| cfg_len_i | input | LEN_W | Packet length in words |
| cfg_sync_lim_i | input | 6 | Bit-error tolerance for acquisition |
| cfg_err_lim_i | input | 6 | Bit-error limit above which a locked word is bad |
| cfg_loss_run_i | input | RUN_W | Consecutive bad words that drop lock |
| rx_data_i | input | 32 | Received data, four byte lanes |
| rx_vld_i | input | 4 | Per-lane valid flags |
| cnt_clr_i | input | 1 | Clear strobe for all counters |
| rd_addr_i | input | 2 | Counter select |
| rd_data_o | output | CNT_W | Selected counter value |
| sync_o | output | 1 | Lock state |

## Verification
A word's effect is due two rising edges after its last byte is presented. The first edge registers the compacted word and the second updates the counters and the lock flag. Most scenarios stream their words and then idle several cycles before reading the counters at a falling edge, so every pending update has landed. The latency scenario instead samples at the falling edge between the two edges, expecting the old value, and again after the second edge, expecting the new one. The loss scenario pauses mid-stream, likewise after idle cycles, to confirm that lock survives a broken run of bad words.

// File: rtl/pv_pkg.sv
package pv_pkg;
  localparam int unsigned BYTES = 4;
  localparam int unsigned DW    = 8 * BYTES;
  localparam int unsigned LIM_W = $clog2(DW + 1);
  localparam logic [DW-1:0] PRBS_POLY = 32'h8020_0003;

  typedef enum logic [1:0] {
    PAT_FIX  = 2'd0,
    PAT_INC  = 2'd1,
    PAT_PRBS = 2'd2,
    PAT_RSV  = 2'd3
  } pat_mode_e;

  typedef enum logic [1:0] {
    SEL_BIT  = 2'd0,
    SEL_BYTE = 2'd1,
    SEL_GOOD = 2'd2,
    SEL_LOSS = 2'd3
  } cnt_sel_e;

  localparam int unsigned NCNT = 4;

  function automatic logic [DW-1:0] pat_step(pat_mode_e m, logic [DW-1:0] s);
    case (m)
      PAT_INC:  return s + 1'b1;
      PAT_PRBS: return (s >> 1) ^ (s[0] ? PRBS_POLY : '0);
      default:  return s;
    endcase
  endfunction
endpackage

// File: rtl/pv_align.sv
module pv_align
  import pv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    data_i,
  input  logic [BYTES-1:0] vld_i,
  output logic [DW-1:0]    word_o,
  output logic             word_vld_o
);
  localparam int unsigned MW = 8 * (2 * BYTES - 1);
  localparam int unsigned LW = 8 * (BYTES - 1);
  localparam int unsigned PW = $clog2(2 * BYTES);

  logic [LW-1:0] buf_q, buf_d;
  logic [PW-1:0] fill_q, fill_d;
  logic [MW-1:0] merged;
  logic [PW-1:0] pos;
  logic          wv_d;

  // pack valid lanes behind the leftover bytes
  always_comb begin
    merged = MW'(buf_q);
    pos    = fill_q;
    for (int i = 0; i < BYTES; i++) begin
      if (vld_i[i]) begin
        merged[8*int'(pos) +: 8] = data_i[8*i +: 8];
        pos = pos + 1'b1;
      end
    end
    wv_d = (pos >= PW'(BYTES));
    if (wv_d) begin
      buf_d  = merged[MW-1:DW];
      fill_d = pos - PW'(BYTES);
    end else begin
      buf_d  = merged[LW-1:0];
      fill_d = pos;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      fill_q     <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      buf_q      <= buf_d;
      fill_q     <= fill_d;
      word_vld_o <= wv_d;
      if (wv_d) word_o <= merged[DW-1:0];
    end
  end

  p_fill_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < PW'(BYTES));

  p_no_word_on_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i == '0) |=> !word_vld_o);
endmodule

// File: rtl/pv_gen.sv
module pv_gen
  import pv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pat_mode_e mode_i,
  input  logic [DW-1:0] pat_i,
  input  logic      hunt_i,
  input  logic      adv_i,
  output logic [DW-1:0] exp_o
);
  logic [DW-1:0] st_q;

  // while hunting the seed is presented directly, no load cycle
  assign exp_o = hunt_i ? pat_i : st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (adv_i) st_q <= pat_step(mode_i, exp_o);
  end

  p_hold_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(st_q));
endmodule

// File: rtl/pv_sat_cnt.sv
module pv_sat_cnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  q_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W:0] sum;
  assign sum = {1'b0, q_o} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (sum[W]) q_o <= MAXV;
    else             q_o <= sum[W-1:0];
  end

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && q_o == MAXV) |=> (q_o == MAXV));

  p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/pkt_verifier.sv
module pkt_verifier
  import pv_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_mode_i,
  input  logic [DW-1:0]    cfg_pat_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [LIM_W-1:0] cfg_sync_lim_i,
  input  logic [LIM_W-1:0] cfg_err_lim_i,
  input  logic [RUN_W-1:0] cfg_loss_run_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic [BYTES-1:0] rx_vld_i,
  input  logic             cnt_clr_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             sync_o
);
  logic [DW-1:0] word, exp_w, diff;
  logic          wv;
  logic          sync_q;
  logic [LIM_W-1:0] nbits, nbytes;
  logic [LEN_W-1:0] wcnt_q, len_eff;
  logic          pkt_bad_q;
  logic [RUN_W-1:0] run_q, run_lim;
  logic [RUN_W:0]   run_nx;
  logic acq_ok, in_word, bad_w, run_hit, drop, accept, last, bad_acc;

  logic [LIM_W-1:0] inc [NCNT];
  logic [CNT_W-1:0] cnt [NCNT];

  pv_align u_align (
    .clk_i, .rst_ni,
    .data_i(rx_data_i), .vld_i(rx_vld_i),
    .word_o(word), .word_vld_o(wv)
  );

  pv_gen u_gen (
    .clk_i, .rst_ni,
    .mode_i(pat_mode_e'(cfg_mode_i)), .pat_i(cfg_pat_i),
    .hunt_i(!sync_q), .adv_i(accept), .exp_o(exp_w)
  );

  assign diff  = word ^ exp_w;
  assign nbits = LIM_W'($countones(diff));

  always_comb begin
    nbytes = '0;
    for (int b = 0; b < BYTES; b++)
      if (diff[8*b +: 8] != 8'h00) nbytes = nbytes + 1'b1;
  end

  assign len_eff = (cfg_len_i == '0) ? LEN_W'(1) : cfg_len_i;
  assign run_lim = (cfg_loss_run_i == '0) ? RUN_W'(1) : cfg_loss_run_i;
  assign run_nx  = {1'b0, run_q} + 1'b1;

  assign acq_ok  = wv && !sync_q && (nbits <= cfg_sync_lim_i);
  assign in_word = wv && sync_q;
  assign bad_w   = nbits > cfg_err_lim_i;
  assign run_hit = run_nx >= {1'b0, run_lim};
  assign drop    = in_word && bad_w && run_hit;
  assign accept  = acq_ok || (in_word && !drop);
  assign last    = (wcnt_q == len_eff - 1'b1);
  assign bad_acc = ((wcnt_q == '0) ? 1'b0 : pkt_bad_q) | (nbits != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      wcnt_q    <= '0;
      pkt_bad_q <= 1'b0;
      run_q     <= '0;
    end else begin
      if (acq_ok)    sync_q <= 1'b1;
      else if (drop) sync_q <= 1'b0;

      if (drop) begin
        wcnt_q    <= '0;
        pkt_bad_q <= 1'b0;
      end else if (accept) begin
        if (last) begin
          wcnt_q    <= '0;
          pkt_bad_q <= 1'b0;
        end else begin
          wcnt_q    <= wcnt_q + 1'b1;
          pkt_bad_q <= bad_acc;
        end
      end

      if (drop || acq_ok || (in_word && !bad_w)) run_q <= '0;
      else if (in_word && bad_w)                 run_q <= run_nx[RUN_W-1:0];
    end
  end

  assign inc[SEL_BIT]  = in_word ? nbits  : '0;
  assign inc[SEL_BYTE] = in_word ? nbytes : '0;
  assign inc[SEL_GOOD] = LIM_W'(accept && last && !bad_acc);
  assign inc[SEL_LOSS] = LIM_W'(drop);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    pv_sat_cnt #(.W(CNT_W), .IW(LIM_W)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i(cnt_clr_i), .inc_i(inc[g]), .q_o(cnt[g])
    );
  end

  assign rd_data_o = cnt[rd_addr_i];
  assign sync_o    = sync_q;

  p_lock_needs_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(wv));

  p_hunt_no_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_q && !cnt_clr_i) |=> ($stable(cnt[SEL_BIT]) && $stable(cnt[SEL_BYTE])));

  p_loss_counted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_q) && !$past(cnt_clr_i)) |->
      ((cnt[SEL_LOSS] != $past(cnt[SEL_LOSS])) || (&cnt[SEL_LOSS])));

  p_bytes_le_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[SEL_BYTE] <= inc[SEL_BIT]));
endmodule

// File: tb/pkt_verifier_tb_top.sv
module pkt_verifier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_mode_i = '0;
  logic [31:0] cfg_pat_i = '0;
  logic [7:0]  cfg_len_i = 8'd1;
  logic [5:0]  cfg_sync_lim_i = '0;
  logic [5:0]  cfg_err_lim_i = '0;
  logic [7:0]  cfg_loss_run_i = 8'd1;
  logic [31:0] rx_data_i = '0;
  logic [3:0]  rx_vld_i = '0;
  logic        cnt_clr_i = 1'b0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        sync_o;

  int n_cmp = 0;
  int n_mis = 0;
  bit done = 0;

  logic [7:0] bq [0:255];
  int nb = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkt_verifier dut_i (.*);

  function automatic logic [31:0] bnext(input logic [1:0] m, input logic [31:0] s);
    if (m == 2'd1) return s + 32'd1;
    if (m == 2'd2) return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr_i = a[1:0];
    #1;
    v = int'(rd_data_o);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic setup(input logic [1:0] m, input logic [31:0] p, input int len,
                       input int sl, input int el, input int run);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_mode_i = m; cfg_pat_i = p; cfg_len_i = len[7:0];
    cfg_sync_lim_i = sl[5:0]; cfg_err_lim_i = el[5:0]; cfg_loss_run_i = run[7:0];
    rx_vld_i = '0; cnt_clr_i = 1'b0; nb = 0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic push(input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      bq[nb] = w[8*k +: 8];
      nb++;
    end
  endtask

  function automatic logic [3:0] mpick(input int k);
    case (k % 6)
      0: return 4'b0101;
      1: return 4'b1110;
      2: return 4'b0000;
      3: return 4'b1000;
      4: return 4'b1111;
      default: return 4'b0110;
    endcase
  endfunction

  task automatic flush(input bit sparse);
    int r = 0;
    int m = 0;
    logic [3:0] msk;
    while (r < nb) begin
      @(negedge clk_i);
      msk = sparse ? mpick(m) : 4'hF;
      m++;
      rx_vld_i = '0;
      rx_data_i = 32'hDEAD_BEEF;
      for (int l = 0; l < 4; l++) begin
        if (msk[l] && r < nb) begin
          rx_data_i[8*l +: 8] = bq[r];
          rx_vld_i[l] = 1'b1;
          r++;
        end
      end
    end
    @(negedge clk_i);
    rx_vld_i = '0;
    nb = 0;
    idle(4);
  endtask

  task automatic t_reset;
    int v;
    setup(2'd0, 32'h0, 4, 0, 0, 1);
    chk("R3 reset sync", int'(sync_o), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk("R7 reset counter", v, 0);
    end
  endtask

  task automatic t_fixed_full;
    int v;
    setup(2'd0, 32'hA5C3_0F96, 4, 0, 0, 1);
    for (int i = 0; i < 8; i++) push(32'hA5C3_0F96);
    flush(0);
    chk("R3 fixed lock", int'(sync_o), 1);
    rd(2, v); chk("R6 fixed good", v, 2);
    rd(0, v); chk("R4 fixed bits", v, 0);
    rd(1, v); chk("R4 fixed bytes", v, 0);
    rd(3, v); chk("R7 fixed loss", v, 0);
  endtask

  task automatic t_compact_inc;
    int v;
    logic [31:0] s = 32'hFFFF_FFFE;
    setup(2'd1, s, 3, 0, 0, 1);
    for (int i = 0; i < 9; i++) begin push(s); s = bnext(2'd1, s); end
    flush(1);
    chk("R1 sparse lock", int'(sync_o), 1);
    rd(2, v); chk("R1 R2 sparse incr good", v, 3);
    rd(0, v); chk("R1 sparse bits", v, 0);
  endtask

  task automatic t_prbs_errors_clear;
    int v;
    logic [31:0] s = 32'h0000_0001;
    logic [31:0] w;
    setup(2'd2, s, 4, 0, 40, 1);
    for (int i = 0; i < 12; i++) begin
      w = s;
      if (i == 2) w = w ^ 32'h0000_0010;
      if (i == 5) w = w ^ 32'h0003_0100;
      push(w);
      s = bnext(2'd2, s);
    end
    flush(1);
    rd(0, v); chk("R4 prbs bits", v, 4);
    rd(1, v); chk("R4 prbs bytes", v, 3);
    rd(2, v); chk("R2 R6 prbs good", v, 1);
    @(negedge clk_i); cnt_clr_i = 1'b1;
    @(negedge clk_i); cnt_clr_i = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(a, v); chk("R9 cleared", v, 0);
    end
    chk("R9 lock kept", int'(sync_o), 1);
    for (int i = 0; i < 4; i++) begin push(s); s = bnext(2'd2, s); end
    flush(0);
    rd(2, v); chk("R9 count after clear", v, 1);
  endtask

  task automatic t_acquire;
    int v;
    setup(2'd1, 32'h100, 2, 2, 0, 1);
    push(32'h103); push(32'h101); push(32'h102); push(32'h103);
    flush(0);
    chk("R3 tolerant lock", int'(sync_o), 1);
    rd(0, v); chk("R4 acq bits not counted", v, 0);
    rd(2, v); chk("R6 acq packet bad", v, 1);
    setup(2'd1, 32'h100, 2, 1, 0, 1);
    push(32'h103);
    flush(0);
    chk("R3 over limit stays unlocked", int'(sync_o), 0);
    push(32'h100); push(32'h101);
    flush(0);
    chk("R3 later lock", int'(sync_o), 1);
    rd(2, v); chk("R3 seed held while hunting", v, 1);
  endtask

  task automatic t_loss;
    int v;
    logic [31:0] w = 32'hA5A5_A5A5;
    setup(2'd0, w, 100, 0, 0, 3);
    push(w); push(w ^ 32'h1); push(w ^ 32'h2); push(w); push(w ^ 32'h4); push(w ^ 32'h8);
    flush(0);
    chk("R5 broken run keeps lock", int'(sync_o), 1);
    rd(0, v); chk("R5 bits so far", v, 4);
    push(w ^ 32'h10);
    flush(0);
    chk("R5 lock dropped", int'(sync_o), 0);
    rd(3, v); chk("R5 loss count", v, 1);
    rd(0, v); chk("R4 dropping word counted", v, 5);
    push(w);
    flush(0);
    chk("R5 resync on seed", int'(sync_o), 1);
  endtask

  task automatic t_latency;
    int v;
    setup(2'd0, 32'h1234_5678, 4, 0, 0, 1);
    push(32'h1234_5678);
    flush(0);
    @(negedge clk_i);
    rx_data_i = 32'h1234_5679; rx_vld_i = 4'hF;
    @(negedge clk_i);
    rx_vld_i = '0;
    rd(0, v); chk("R10 not after first edge", v, 0);
    @(negedge clk_i);
    rd(0, v); chk("R10 after second edge", v, 1);
  endtask

  task automatic t_saturate;
    int v;
    setup(2'd0, 32'h0, 4, 0, 32, 1);
    @(negedge clk_i); rx_data_i = 32'h0; rx_vld_i = 4'hF;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk_i); rx_data_i = 32'hFFFF_FFFF;
    end
    @(negedge clk_i); rx_vld_i = '0;
    idle(4);
    rd(0, v); chk("R8 bits saturate", v, CMAX);
    rd(1, v); chk("R8 bytes below max", v, 8400);
    chk("R8 lock kept", int'(sync_o), 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fixed_full();
    t_compact_inc();
    t_prbs_errors_clear();
    t_acquire();
    t_loss();
    t_latency();
    t_saturate();
    finish_run();
  end
endmodule